// File: doc/BRIEF.md
# Board Interrupt Aggregator with Edge Latching and Masking

This block gathers eleven board interrupt sources into one registered interrupt request. Four of them are event sources: a change of level in either direction sets a sticky status bit, and software clears that bit by writing a one to it. The other seven are level sources. Their status bits follow the synchronised input, and software cannot change them. Each source has a mask bit, where 1 means enabled. The aggregate request is the OR of every status bit whose mask bit is set.

Alongside the aggregate, three direct outputs need no register state. Two memory-card detect groups are each the OR of a pair of detect pins. The power-management interrupt passes straight through.

Software reaches the block through a flat register port with one-cycle writes and combinational reads. The port gives access to:
- a status word
- a word holding the raw synchronised levels of the event sources
- a mask, changed through separate set and clear offsets

Top module: `irq_aggregator`

## Requirements
- R1: Status bits [3:0] are set by any rising or falling transition of `edge_src[3:0]` (bit 0 low battery, bit 1 push button, bit 2 OTG over-current, bit 3 host over-current). The bit reads 1 within SYNC_STAGES+1 clock cycles of the input change.
- R2: A write to offset 0x16 clears each event status bit whose data bit [3:0] is 1. Bits written with 0 keep their value.
- R3: Status bits [14:8] equal `level_src[6:0]` (level_src[k] appears at bit 8+k) after SYNC_STAGES cycles. Writes to offset 0x16 have no effect on them.
- R4: Status bits [7:4] and bit 15 always read 0. After reset the event status bits and all mask bits are 0.
- R5: Writing offset 0x1A sets the mask bits given by ones in the data. Writing offset 0x1C clears them. Both offsets read back the mask in the status layout, with reserved positions 0. Masked sources still show in the status word.
- R6: When a write to offset 0x1A enables a source whose status bit is already 1, `agg_irq` is 1 in the cycle after that write.
- R7: `agg_irq` is 1 exactly when some status bit and its mask bit are both 1. With an all-zero mask it is 0.
- R8: `card1_irq` = sd1_det OR ms1_det, `card2_irq` = sd2_det OR ms2_det, and `pmic_irq_out` = `pmic_irq_in`. All three are combinational.
- R9: Offset 0x18 returns the synchronised levels of `edge_src[3:0]` in bits [3:0], with all other bits 0. Any offset not listed here reads 0.
- R10: If a transition on an event source and a write-one-to-clear of its bit land in the same cycle, the bit stays set.
- R11: Input levels that are already present when reset is released do not count as transitions. No event bit is set by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | One-cycle write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| edge_src | input | 4 | Event-type interrupt sources |
| level_src | input | 7 | Level-type interrupt sources |
| sd1_det | input | 1 | Card slot 1, SD detect |
| ms1_det | input | 1 | Card slot 1, memory-stick detect |
| sd2_det | input | 1 | Card slot 2, SD detect |
| ms2_det | input | 1 | Card slot 2, memory-stick detect |
| pmic_irq_in | input | 1 | Power-management primary interrupt |
| card1_irq | output | 1 | Slot 1 detect group |
| card2_irq | output | 1 | Slot 2 detect group |
| pmic_irq_out | output | 1 | Power-management interrupt, passed through |
| agg_irq | output | 1 | Aggregate of unmasked status bits |

## Verification
The checker watches a set of rules on every cycle:
- a detected transition always leaves its bit set, even against a simultaneous clear
- a clear without a coincident transition drops the bit
- reserved status positions stay zero
- a mask clear removes the bits it names
- enabling a pending event source raises the aggregate on the next cycle
- an all-zero mask keeps the aggregate low

Other behaviours depend on what the sources do over time, so only the bench scenarios show them. These are: both transition directions on every event source, the full 128-pattern sweep of the level inputs, all mask patterns over a fixed level pattern, the reset-time levels that must not count as transitions, and the exact cycle in which a transition and a clear collide.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W    = 16;
    localparam int NUM_EDGE  = 4;
    localparam int NUM_LEVEL = 7;
    localparam int NUM_SRC   = NUM_EDGE + NUM_LEVEL;
    localparam int LEVEL_LSB = 8;

    localparam logic [7:0] OFS_STATUS   = 8'h16;
    localparam logic [7:0] OFS_CURSTATE = 8'h18;
    localparam logic [7:0] OFS_MASK_SET = 8'h1A;
    localparam logic [7:0] OFS_MASK_CLR = 8'h1C;

    // compact source vector {level, edge} -> register layout
    function automatic logic [DATA_W-1:0] to_reg(input logic [NUM_SRC-1:0] v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[NUM_EDGE-1:0] = v[NUM_EDGE-1:0];
        r[LEVEL_LSB +: NUM_LEVEL] = v[NUM_SRC-1:NUM_EDGE];
        return r;
    endfunction

    function automatic logic [NUM_SRC-1:0] from_reg(input logic [DATA_W-1:0] r);
        return {r[LEVEL_LSB +: NUM_LEVEL], r[NUM_EDGE-1:0]};
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 11,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg_q [STAGES];
    logic [WIDTH-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/irq_edge_bank.sv
module irq_edge_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         arm,
    input  logic [N-1:0] src,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat,
    output logic [N-1:0] pulse
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] stat;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        pulse       = arm ? (src ^ bank_q.prev) : '0;
        bank_d.prev = src;
        // a new transition outranks a clear in the same cycle
        bank_d.stat = (bank_q.stat & ~clr) | pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign stat = bank_q.stat;
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [3:0]        edge_src,
    input  logic [6:0]        level_src,
    input  logic              sd1_det,
    input  logic              ms1_det,
    input  logic              sd2_det,
    input  logic              ms2_det,
    input  logic              pmic_irq_in,
    output logic              card1_irq,
    output logic              card2_irq,
    output logic              pmic_irq_out,
    output logic              agg_irq
);
    localparam int ARM_LIM = SYNC_STAGES + 1;
    localparam int ARM_W   = $clog2(ARM_LIM + 1);

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [ARM_W-1:0]   arm_cnt;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NUM_SRC-1:0]   src_sync;
    logic [NUM_EDGE-1:0]  edge_sync;
    logic [NUM_LEVEL-1:0] lvl_sync;
    logic [NUM_EDGE-1:0]  edge_stat;
    logic [NUM_EDGE-1:0]  edge_pulse;
    logic [NUM_EDGE-1:0]  edge_clr;
    logic [NUM_SRC-1:0]   mask_cur;
    logic [NUM_SRC-1:0]   status_vec;
    logic                 armed;
    logic                 hit_status, hit_cur, hit_set, hit_clr;

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({level_src, edge_src}),
        .dout  (src_sync)
    );

    assign edge_sync = src_sync[NUM_EDGE-1:0];
    assign lvl_sync  = src_sync[NUM_SRC-1:NUM_EDGE];

    assign hit_status = (reg_addr == ADDR_W'(OFS_STATUS));
    assign hit_cur    = (reg_addr == ADDR_W'(OFS_CURSTATE));
    assign hit_set    = (reg_addr == ADDR_W'(OFS_MASK_SET));
    assign hit_clr    = (reg_addr == ADDR_W'(OFS_MASK_CLR));

    assign edge_clr = (reg_wr && hit_status) ? reg_wdata[NUM_EDGE-1:0] : '0;
    assign armed    = (st_q.arm_cnt == ARM_W'(ARM_LIM));

    irq_edge_bank #(.N(NUM_EDGE)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (armed),
        .src   (edge_sync),
        .clr   (edge_clr),
        .stat  (edge_stat),
        .pulse (edge_pulse)
    );

    always_comb begin
        st_d = st_q;
        if (!armed) st_d.arm_cnt = st_q.arm_cnt + 1'b1;
        if (reg_wr && hit_set) st_d.mask = st_q.mask | from_reg(reg_wdata);
        if (reg_wr && hit_clr) st_d.mask = st_q.mask & ~from_reg(reg_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_cur   = st_q.mask;
    assign status_vec = {lvl_sync, edge_stat};

    always_comb begin
        reg_rdata = '0;
        if (hit_status)          reg_rdata = to_reg(status_vec);
        else if (hit_cur)        reg_rdata = 16'(edge_sync);
        else if (hit_set || hit_clr) reg_rdata = to_reg(mask_cur);
    end

    assign agg_irq      = |(status_vec & mask_cur);
    assign card1_irq    = sd1_det | ms1_det;
    assign card2_irq    = sd2_det | ms2_det;
    assign pmic_irq_out = pmic_irq_in;
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata,
    input logic              agg_irq,
    input logic [3:0]        edge_stat,
    input logic [3:0]        edge_pulse,
    input logic [10:0]       mask_cur
);
    logic wr_status, wr_set, wr_clr;
    assign wr_status = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));
    assign wr_set    = reg_wr && (reg_addr == ADDR_W'(OFS_MASK_SET));
    assign wr_clr    = reg_wr && (reg_addr == ADDR_W'(OFS_MASK_CLR));

    AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_pulse != 4'b0) |=> ((edge_stat & $past(edge_pulse)) == $past(edge_pulse))); // R1

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && ((reg_wdata[3:0] & ~edge_pulse) != 4'b0))
        |=> ((edge_stat & $past(reg_wdata[3:0] & ~edge_pulse)) == 4'b0)); // R2

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_STATUS)) |-> ((reg_rdata & 16'h80F0) == 16'h0)); // R4

    AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((mask_cur & $past(from_reg(reg_wdata))) == 11'b0)); // R5

    AST_UNMASK_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_set && ((reg_wdata[3:0] & edge_stat) != 4'b0)) |=> agg_irq); // R6

    AST_QUIET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_cur == 11'b0) |-> !agg_irq); // R7

    AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && ((reg_wdata[3:0] & edge_pulse) != 4'b0))
        |=> ((edge_stat & $past(reg_wdata[3:0] & edge_pulse)) == $past(reg_wdata[3:0] & edge_pulse))); // R10
endmodule

bind irq_aggregator irq_aggregator_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .agg_irq    (agg_irq),
    .edge_stat  (edge_stat),
    .edge_pulse (edge_pulse),
    .mask_cur   (mask_cur)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
    localparam logic [7:0] A_STAT = 8'h16;
    localparam logic [7:0] A_CUR  = 8'h18;
    localparam logic [7:0] A_SET  = 8'h1A;
    localparam logic [7:0] A_CLR  = 8'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic [3:0]  edge_src = 4'b0101;
    logic [6:0]  level_src = 7'h0;
    logic        sd1_det = 0, ms1_det = 0, sd2_det = 0, ms2_det = 0, pmic_irq_in = 0;
    logic        card1_irq, card2_irq, pmic_irq_out, agg_irq;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_edge;

    always #2 clk = ~clk;

    irq_aggregator u_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .edge_src(edge_src),
        .level_src(level_src), .sd1_det(sd1_det), .ms1_det(ms1_det),
        .sd2_det(sd2_det), .ms2_det(ms2_det), .pmic_irq_in(pmic_irq_in),
        .card1_irq(card1_irq), .card2_irq(card2_irq),
        .pmic_irq_out(pmic_irq_out), .agg_irq(agg_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [15:0] stat_word(input logic [3:0] e, input logic [6:0] l);
        return {1'b0, l, 4'b0, e};
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        // R4 R11: levels present at reset release are not transitions
        rd(A_STAT, d); chk("R11 no event from reset-time levels", d, 16'h0);
        rd(A_SET, d);  chk("R4 mask reset", d, 16'h0);
        chk("R4 agg low after reset", {15'b0, agg_irq}, 16'h0);
        rd(A_CUR, d);  chk("R9 current state", d, 16'h0005);
        rd(8'h00, d);  chk("R9 unlisted offset reads 0", d, 16'h0);

        // R1 falling edges, R2 partial clear
        @(negedge clk); edge_src = 4'b0000;
        settle();
        rd(A_STAT, d); chk("R1 falling edges latch", d, 16'h0005);
        wr(A_STAT, 16'h0001);
        rd(A_STAT, d); chk("R2 clear bit0 only", d, 16'h0004);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, d); chk("R2 writing 0 keeps bit", d, 16'h0004);
        wr(A_STAT, 16'h0004);
        rd(A_STAT, d); chk("R2 clear bit2", d, 16'h0000);

        // R1 per-bit sweep, both directions
        for (int i = 0; i < 4; i++) begin
            for (int dir = 0; dir < 2; dir++) begin
                @(negedge clk); edge_src[i] = ~edge_src[i];
                settle();
                exp_edge = 4'(1 << i);
                rd(A_STAT, d); chk("R1 single-bit transition", d, {12'b0, exp_edge});
                rd(A_CUR, d);  chk("R9 raw level", d, {12'b0, edge_src});
                wr(A_STAT, 16'h000F);
                rd(A_STAT, d); chk("R2 full clear", d, 16'h0);
            end
        end

        // R3 level sweep, writes ignored
        for (int v = 0; v < 128; v++) begin
            @(negedge clk); level_src = 7'(v);
            settle();
            rd(A_STAT, d); chk("R3 level mirror", d, stat_word(4'b0, 7'(v)));
            if (v % 16 == 5) begin
                wr(A_STAT, 16'h7F00);
                rd(A_STAT, d); chk("R3 write has no effect", d, stat_word(4'b0, 7'(v)));
            end
        end
        @(negedge clk); level_src = 7'h0;
        settle();

        // R5 mask set/clear/readback
        wr(A_SET, 16'hFFFF);
        rd(A_SET, d); chk("R5 mask set readback", d, 16'h7F0F);
        wr(A_CLR, 16'h0F03);
        rd(A_CLR, d); chk("R5 mask partial clear", d, 16'h700C);
        wr(A_CLR, 16'hFFFF);
        rd(A_SET, d); chk("R5 mask cleared", d, 16'h0);

        // R5 R6 per-source unmask
        for (int b = 0; b < 11; b++) begin
            logic [15:0] bitw;
            if (b < 4) begin
                bitw = 16'(1 << b);
                @(negedge clk); edge_src[b] = ~edge_src[b];
            end else begin
                bitw = 16'(1 << (b + 4));
                @(negedge clk); level_src[b-4] = 1'b1;
            end
            settle();
            rd(A_STAT, d); chk("R5 masked source still in status", d, bitw);
            chk("R7 masked source keeps agg low", {15'b0, agg_irq}, 16'h0);
            wr(A_SET, bitw);
            chk("R6 unmask pending fires", {15'b0, agg_irq}, 16'h1);
            wr(A_CLR, bitw);
            chk("R5 remask drops agg", {15'b0, agg_irq}, 16'h0);
            if (b < 4) wr(A_STAT, bitw);
            else begin @(negedge clk); level_src[b-4] = 1'b0; end
            settle();
        end

        // R7 all level-mask patterns against a fixed level pattern
        @(negedge clk); level_src = 7'h55;
        settle();
        for (int m = 0; m < 128; m++) begin
            wr(A_CLR, 16'hFFFF);
            wr(A_SET, {1'b0, 7'(m), 8'h00});
            chk("R7 aggregate of unmasked", {15'b0, agg_irq}, {15'b0, |(7'(m) & 7'h55)});
        end
        wr(A_CLR, 16'hFFFF);
        @(negedge clk); level_src = 7'h0;
        settle();

        // R8 grouped outputs
        for (int p = 0; p < 32; p++) begin
            {sd1_det, ms1_det, sd2_det, ms2_det, pmic_irq_in} = 5'(p);
            #1;
            chk("R8 grouped outputs", {13'b0, card1_irq, card2_irq, pmic_irq_out},
                {13'b0, sd1_det | ms1_det, sd2_det | ms2_det, pmic_irq_in});
        end

        // R10 transition and clear in the same cycle
        @(negedge clk); edge_src[1] = ~edge_src[1];
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 16'h0002;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(A_STAT, d); chk("R10 edge wins over clear", d, 16'h0002);
        wr(A_STAT, 16'h0002);
        rd(A_STAT, d); chk("R2 later clear works", d, 16'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule